// File: doc/BRIEF.md
# Shared Column Overflow Event Counter

This block counts pixel overflow events for a whole column with a single adder and a small memory indexed by row, rather than a counter in every pixel. Each row keeps a one-bit flag that the pixel's comparator sets on an overflow. A sequencer walks the rows in ascending order. At each row it selects the row, adds the row's flag to that row's stored count, latches the sum and writes it back to the same address, then clears the flag. Each frame makes 2^CNT_W complete passes over the rows, so every pixel can record up to 2^CNT_W events per frame. The counter clock must therefore run at 2·ROWS·2^CNT_W times the frame rate, because each row visit takes two cycles.

A one-cycle `frameStart` pulse begins a frame. On the first pass the stored counts are treated as zero, so nothing carries over from the previous frame. Counts saturate at the all-ones value, and each row keeps a sticky saturation bit. On the final pass the sums are also copied into a separate result bank. A readout port serves that bank, so any row's final count can be read while the next frame is already accumulating. A flag clear never discards an event that the adder did not see. An event that arrives while its row is being cleared, or after the row's flag was sampled, stays pending until the next visit.

Top module: `ovf_col_counter`

## Requirements
- R1: After reset, `rowSel`, `flagClr`, `wrStrobe` and `frameDone` are all low, and the readout port returns count 0 and saturation 0 for every row.
- R2: Every row visit lasts two cycles and `rowSel` is one-hot on that row for both. In the first cycle `wrStrobe` is 0. In the second cycle `wrStrobe` is 1 and `flagClr` equals `rowSel`. Rows follow in order 0, 1, …, ROWS-1, then 0 again.
- R3: After the clock edge that samples `frameStart`, the next cycle is the first visit of row 0. `frameDone` is high for exactly one cycle, and it first appears 2·ROWS·2^CNT_W edges after the sampling edge. In that cycle, and after it until the next `frameStart`, `rowSel` is 0.
- R4: An isolated event pulse on `rowEvent[r]` adds exactly 1 to row r's count for the frame. Counts from the previous frame do not carry over: a frame with no events yields 0.
- R5: The count saturates at 2^CNT_W-1 and does not wrap. `rdSat` is 1 only if an event was added while the row was already at that maximum, so 2^CNT_W events give 255 with saturation 1, and 255 events give 255 with saturation 0 (for CNT_W = 8).
- R6: An event in the write/clear cycle of its own row always survives. If the flag had just been counted, the new event is counted again on the next visit.
- R7: An event in the first (read) cycle of its own row's visit, with the flag previously clear, is not cleared and is counted on the next visit.
- R8: The readout values (`rdCount`, `rdSat` for `rdRow`) change only during the final pass of a frame. During the next frame's earlier passes they still show the previous frame's results.
- R9: A `frameStart` pulse in the middle of a frame restarts it. Counts restart from zero, and the frame then runs its full length from the new start.
- R10: An event that arrives while no frame is running is held in the row flag and counted during the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rstN | input | 1 | Active-low asynchronous-free synchronous reset |
| frameStart | input | 1 | One-cycle pulse that starts (or restarts) a frame |
| rowEvent | input | ROWS | Per-row overflow event pulses from the pixel comparators |
| rdRow | input | ROW_W | Row whose final count is presented on the readout port |
| rowSel | output | ROWS | One-hot select of the row being visited |
| flagClr | output | ROWS | One-hot flag clear strobe, in the write cycle of a visit |
| wrStrobe | output | 1 | Write-back strobe for the latched sum |
| frameDone | output | 1 | One-cycle pulse once the result bank holds the frame's counts |
| rdCount | output | CNT_W | Final count of row `rdRow` from the last completed frame |
| rdSat | output | 1 | Sticky saturation bit of row `rdRow` from the last completed frame |

## Verification
The assertions rely on two assumptions about the inputs: `frameStart` arrives only as a single-cycle pulse, and `rdRow` addresses an existing row. The checks that the readout holds steady allow for any change of `rdRow`. The stimulus changes inputs only on the falling clock edge and keeps `rdRow` within the row range. Event pulses are single cycles, spaced more than one full pass apart per row, except where a scenario deliberately lands one on a row's read or clear cycle. The sequencer's state itself is not observable at the ports, so the bench places those collision pulses by watching `rowSel` and `wrStrobe`.

// File: rtl/ovfcnt_pkg.sv
package ovfcnt_pkg;
  // Strobes from the row sequencer to the count datapath.
  typedef struct packed {
    logic visit;      // a row visit is in progress
    logic writeBack;  // second cycle of the visit: store sum, clear flag
    logic firstPass;  // first pass of the frame: stored counts read as zero
    logic lastPass;   // final pass: sums also go to the result bank
  } seqStrobes_t;
endpackage

// File: rtl/ovfcnt_seq.sv
module ovfcnt_seq
  import ovfcnt_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int CNT_W = 8,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  output seqStrobes_t      strb,
  output logic [ROW_W-1:0] rowIdx,
  output logic             frameDone
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  logic             active;
  logic             phaseWr;
  logic [CNT_W-1:0] passCnt;
  logic             doneQ;
  logic             lastRow;
  logic             lastPass;

  assign lastRow  = (rowIdx == LAST_ROW);
  assign lastPass = &passCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      phaseWr <= 1'b0;
      rowIdx  <= '0;
      passCnt <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= active & phaseWr & lastRow & lastPass & ~frameStart;
      if (frameStart) begin
        active  <= 1'b1;
        phaseWr <= 1'b0;
        rowIdx  <= '0;
        passCnt <= '0;
      end else if (active) begin
        if (!phaseWr) begin
          phaseWr <= 1'b1;
        end else begin
          phaseWr <= 1'b0;
          if (lastRow) begin
            rowIdx <= '0;
            if (lastPass) active  <= 1'b0;
            else          passCnt <= passCnt + CNT_W'(1);
          end else begin
            rowIdx <= rowIdx + ROW_W'(1);
          end
        end
      end
    end
  end

  always_comb begin
    strb.visit     = active;
    strb.writeBack = active & phaseWr;
    strb.firstPass = (passCnt == '0);
    strb.lastPass  = lastPass;
  end

  assign frameDone = doneQ;
endmodule

// File: rtl/ovfcnt_dp.sv
module ovfcnt_dp
  import ovfcnt_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int CNT_W = 8,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobes_t      strb,
  input  logic [ROW_W-1:0] rowIdx,
  input  logic [ROWS-1:0]  rowEvent,
  input  logic [ROW_W-1:0] rdRow,
  output logic [ROWS-1:0]  rowSel,
  output logic [ROWS-1:0]  flagClr,
  output logic             wrStrobe,
  output logic [CNT_W-1:0] rdCount,
  output logic             rdSat
);
  logic [ROWS-1:0]  flagQ;
  logic             countedQ;   // flag value the adder consumed this visit
  logic [CNT_W-1:0] sumQ;
  logic             satQ;
  logic [CNT_W-1:0] liveCnt [ROWS];
  logic [ROWS-1:0]  liveSat;
  logic [CNT_W-1:0] resCnt  [ROWS];
  logic [ROWS-1:0]  resSat;

  logic             curFlag;
  logic [CNT_W-1:0] baseCnt;
  logic             baseSat;
  logic             atMax;
  logic [CNT_W-1:0] sumNext;
  logic             satNext;
  logic             latchNow;

  // Row decode and per-row flag bits: a new event beats the clear.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic clrHit;
    assign rowSel[r]  = strb.visit & (rowIdx == ROW_W'(r));
    assign flagClr[r] = rowSel[r] & strb.writeBack;
    assign clrHit     = flagClr[r] & countedQ;
    always_ff @(posedge clk) begin
      if (!rstN) flagQ[r] <= 1'b0;
      else       flagQ[r] <= rowEvent[r] | (flagQ[r] & ~clrHit);
    end
  end

  assign wrStrobe = strb.writeBack;
  assign latchNow = strb.visit & ~strb.writeBack;

  // Saturating single-bit accumulate.
  always_comb begin
    curFlag = flagQ[rowIdx];
    baseCnt = strb.firstPass ? '0   : liveCnt[rowIdx];
    baseSat = strb.firstPass ? 1'b0 : liveSat[rowIdx];
    atMax   = &baseCnt;
    sumNext = (curFlag & ~atMax) ? baseCnt + CNT_W'(1) : baseCnt;
    satNext = baseSat | (curFlag & atMax);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumQ     <= '0;
      satQ     <= 1'b0;
      countedQ <= 1'b0;
    end else if (latchNow) begin
      sumQ     <= sumNext;
      satQ     <= satNext;
      countedQ <= curFlag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ROWS; i++) begin
        liveCnt[i] <= '0;
        resCnt[i]  <= '0;
      end
      liveSat <= '0;
      resSat  <= '0;
    end else if (strb.writeBack) begin
      liveCnt[rowIdx] <= sumQ;
      liveSat[rowIdx] <= satQ;
      if (strb.lastPass) begin
        resCnt[rowIdx] <= sumQ;
        resSat[rowIdx] <= satQ;
      end
    end
  end

  assign rdCount = resCnt[rdRow];
  assign rdSat   = resSat[rdRow];
endmodule

// File: rtl/ovf_col_counter.sv
module ovf_col_counter
  import ovfcnt_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int CNT_W = 8,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic [ROWS-1:0]  rowEvent,
  input  logic [ROW_W-1:0] rdRow,
  output logic [ROWS-1:0]  rowSel,
  output logic [ROWS-1:0]  flagClr,
  output logic             wrStrobe,
  output logic             frameDone,
  output logic [CNT_W-1:0] rdCount,
  output logic             rdSat
);
  seqStrobes_t      strb;
  logic [ROW_W-1:0] rowIdx;

  ovfcnt_seq #(.ROWS(ROWS), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rstN(rstN), .frameStart(frameStart),
    .strb(strb), .rowIdx(rowIdx), .frameDone(frameDone)
  );

  ovfcnt_dp #(.ROWS(ROWS), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rowIdx(rowIdx),
    .rowEvent(rowEvent), .rdRow(rdRow),
    .rowSel(rowSel), .flagClr(flagClr), .wrStrobe(wrStrobe),
    .rdCount(rdCount), .rdSat(rdSat)
  );
endmodule

// File: rtl/ovf_col_counter_chk.sv
module ovf_col_counter_chk #(
  parameter int ROWS  = 8,
  parameter int CNT_W = 8,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input logic             clk,
  input logic             rstN,
  input logic [ROWS-1:0]  rowSel,
  input logic [ROWS-1:0]  flagClr,
  input logic             wrStrobe,
  input logic             frameDone,
  input logic [ROW_W-1:0] rdRow,
  input logic [CNT_W-1:0] rdCount,
  input logic             rdSat
);
  assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rowSel));

  assert_write_follows_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> (rowSel == $past(rowSel)) && !$past(wrStrobe) && (rowSel != '0));

  assert_clear_in_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr != '0) |-> wrStrobe && (flagClr == rowSel));

  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> (rowSel == '0));

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  assert_sat_at_max_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdSat |-> (rdCount == '1));

  assert_readout_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rowSel == '0) |=> (rdCount == $past(rdCount)) || (rdRow != $past(rdRow)));
endmodule

bind ovf_col_counter ovf_col_counter_chk #(.ROWS(ROWS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .rowSel(rowSel), .flagClr(flagClr),
  .wrStrobe(wrStrobe), .frameDone(frameDone), .rdRow(rdRow),
  .rdCount(rdCount), .rdSat(rdSat)
);

// File: tb/ovf_col_counter_tb.sv
module ovf_col_counter_tb;
  localparam int ROWS  = 8;
  localparam int CNT_W = 8;
  localparam int ROW_W = 3;
  localparam int FRAME_EDGES = 2 * ROWS * (1 << CNT_W);
  localparam int MAXC = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             frameStart = 1'b0;
  logic [ROWS-1:0]  rowEvent = '0;
  logic [ROW_W-1:0] rdRow = '0;
  logic [ROWS-1:0]  rowSel;
  logic [ROWS-1:0]  flagClr;
  logic             wrStrobe;
  logic             frameDone;
  logic [CNT_W-1:0] rdCount;
  logic             rdSat;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  ovf_col_counter #(.ROWS(ROWS), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .rowEvent(rowEvent),
    .rdRow(rdRow), .rowSel(rowSel), .flagClr(flagClr), .wrStrobe(wrStrobe),
    .frameDone(frameDone), .rdCount(rdCount), .rdSat(rdSat)
  );

  always #10 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic startFrame();
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  task automatic pulse(int r);
    rowEvent[r] = 1'b1;
    @(negedge clk);
    rowEvent[r] = 1'b0;
  endtask

  task automatic waitDone(inout int n);
    while (!frameDone && n < FRAME_EDGES + 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic waitRowPhase(int r, bit wr);
    while (!(rowSel == ROWS'(1 << r) && wrStrobe == wr)) @(negedge clk);
  endtask

  task automatic expectRow(string req, int r, int cnt, int sat);
    rdRow = ROW_W'(r);
    #1;
    chk(req, int'(rdCount), cnt);
    chk(req, int'(rdSat), sat);
  endtask

  task automatic testReset();
    chk("R1 rowSel", int'(rowSel), 0);
    chk("R1 flagClr", int'(flagClr), 0);
    chk("R1 wrStrobe", int'(wrStrobe), 0);
    chk("R1 frameDone", int'(frameDone), 0);
    expectRow("R1 readout", 0, 0, 0);
    expectRow("R1 readout", 5, 0, 0);
  endtask

  task automatic testSequence();
    int n;
    startFrame();
    chk("R2 c1 rowSel", int'(rowSel), 1);
    chk("R2 c1 wr", int'(wrStrobe), 0);
    chk("R2 c1 clr", int'(flagClr), 0);
    tick();
    chk("R2 c2 rowSel", int'(rowSel), 1);
    chk("R2 c2 wr", int'(wrStrobe), 1);
    chk("R2 c2 clr", int'(flagClr), 1);
    tick();
    chk("R2 c3 rowSel", int'(rowSel), 2);
    chk("R2 c3 wr", int'(wrStrobe), 0);
    repeat (13) tick();
    chk("R2 c16 rowSel", int'(rowSel), 128);
    chk("R2 c16 wr", int'(wrStrobe), 1);
    tick();
    chk("R2 c17 wrap", int'(rowSel), 1);
    n = 17;
    waitDone(n);
    chk("R3 frame length", n, FRAME_EDGES + 1);
    chk("R3 idle at done", int'(rowSel), 0);
    tick();
    chk("R3 done one cycle", int'(frameDone), 0);
    chk("R3 stays idle", int'(rowSel), 0);
    for (int r = 0; r < ROWS; r++) expectRow("R4 empty frame", r, 0, 0);
  endtask

  task automatic testCounts();
    int n = 1;
    startFrame();
    for (int i = 0; i < 22; i++) begin
      for (int r = 0; r < ROWS; r++) rowEvent[r] = (i < 3 * r + 1);
      tick();
      rowEvent = '0;
      repeat (39) tick();
    end
    waitDone(n);
    for (int r = 0; r < ROWS; r++) expectRow("R4 counts", r, 3 * r + 1, 0);
  endtask

  task automatic testNoCarry();
    int n = 1;
    startFrame();
    repeat (20) tick();
    pulse(4);
    waitDone(n);
    for (int r = 0; r < ROWS; r++) expectRow("R4 no carry", r, (r == 4) ? 1 : 0, 0);
  endtask

  task automatic testCollisions();
    int n = 1;
    startFrame();
    pulse(3);
    waitRowPhase(3, 1'b1);
    pulse(3);              // lands on the clear of the visit that counted the first
    waitRowPhase(5, 1'b0);
    pulse(5);              // lands on the read cycle, flag was clear
    waitRowPhase(6, 1'b1);
    pulse(6);              // lands on the clear cycle, flag was clear
    waitDone(n);
    expectRow("R6 clear-cycle after count", 3, 2, 0);
    expectRow("R7 read-cycle event", 5, 1, 0);
    expectRow("R6 clear-cycle event", 6, 1, 0);
    expectRow("R6 untouched row", 0, 0, 0);
  endtask

  task automatic testSaturate();
    int n = 1;
    startFrame();
    rowEvent[2] = 1'b1;        // every visit: 256 events
    waitRowPhase(4, 1'b1);
    tick();
    rowEvent[4] = 1'b1;        // from pass 1 onward: 255 events
    waitDone(n);
    rowEvent = '0;
    expectRow("R5 saturated", 2, MAXC, 1);
    expectRow("R5 max no sat", 4, MAXC, 0);
    expectRow("R5 other row", 0, 0, 0);
  endtask

  task automatic testReadHold();
    int n = 2001;
    startFrame();
    repeat (2000) tick();
    expectRow("R8 hold mid-frame", 2, MAXC, 1);
    expectRow("R8 hold mid-frame", 4, MAXC, 0);
    waitDone(n);
    expectRow("R10 pending flag", 2, 1, 0);
    expectRow("R10 pending flag", 4, 1, 0);
    expectRow("R8 new result", 0, 0, 0);
  endtask

  task automatic testRestart();
    int n;
    startFrame();
    for (int i = 0; i < 3; i++) begin
      pulse(1);
      repeat (39) tick();
    end
    repeat (300) tick();
    startFrame();
    n = 1;
    pulse(1);
    n++;
    repeat (39) tick();
    n += 39;
    pulse(1);
    n++;
    waitDone(n);
    chk("R9 restart length", n, FRAME_EDGES + 1);
    expectRow("R9 restart count", 1, 2, 0);
  endtask

  task automatic testIdleEvent();
    int n = 1;
    repeat (3) tick();
    pulse(7);
    repeat (5) tick();
    startFrame();
    waitDone(n);
    expectRow("R10 idle event", 7, 1, 0);
    expectRow("R10 other row", 6, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSequence();
    testCounts();
    testNoCarry();
    testCollisions();
    testSaturate();
    testReadHold();
    testRestart();
    testIdleEvent();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end
endmodule